// File: doc/BRIEF.md
# Tick-Based Sampling Sequencer

This block runs one measurement session for a pair of position counters. While idle it waits for a one-byte interval command from the host byte stream. A valid command selects one of three tick periods, restarts the tick timer and opens a session. From then on, the block raises a tick once per interval. On each tick it takes both counter inputs in the same clock cycle. It packs them into one record and hands that record to the host write path one byte at a time.

A session ends once the configured number of records has been captured and the last byte of the last record has been accepted. The block then goes idle and waits for the next command. A tick that arrives while the previous record is still being sent drops its snapshot and raises a sticky overrun flag. The periods are given in clock cycles. The defaults correspond to 10 ms, 5 ms and 3 ms at a 12 MHz clock, with 600 records per session.

Top module: `tick_sampler`

## Requirements
- R1: After reset `busy`, `wr_req` and `overrun` are all low.
- R2: While idle, a byte with `rx_valid` high and value 0, 1 or 2 is accepted. Code 0 selects SLOW_CYC cycles, 1 selects MID_CYC and 2 selects FAST_CYC. `busy` is high from the cycle after the accepting edge.
- R3: While idle, any other command value is ignored: `busy` and `wr_req` stay low.
- R4: Command bytes that arrive while `busy` is high are ignored. The running session keeps its period and its tick phase.
- R5: The timer restarts on the accepting edge, so the first tick falls exactly one period later. Each later tick follows the previous one by exactly one period.
- R6: On a tick, `cnt_a` and `cnt_b` are sampled at the same clock edge. The record is {cnt_a, cnt_b}, so `cnt_a` occupies the upper CNT_W bits.
- R7: A record is offered as bytes, most significant byte first. `wr_req` stays high and `wr_data` stays stable until `wr_done`. A byte completes on an edge where both are high, and the next byte is offered in the following cycle.
- R8: A tick that arrives while `wr_req` is high sets `overrun`, and its snapshot is neither sent nor counted. `overrun` holds until the next accepted command, which clears it.
- R9: After NSAMP records have been sent, no further request is made. `busy` is still high one cycle after the edge that completes the final byte and falls at the second edge after it.
- R10: Once a session has ended, a new valid command starts a fresh session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received host byte (interval code) |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| cnt_a | input | CNT_W | Position counter of channel 1 |
| cnt_b | input | CNT_W | Position counter of channel 2 |
| wr_req | output | 1 | A byte is offered to the host write path |
| wr_data | output | 8 | Offered byte |
| wr_done | input | 1 | Write path takes the offered byte this cycle |
| busy | output | 1 | A session is in progress |
| overrun | output | 1 | A tick was dropped in this session |

## Verification
Every record carries the counter values from its tick edge. The bench drives counters that encode the cycle number, so a timer loaded with the wrong period, a phase error or a restart caused by a stray command shows up at the ports as soon as the first record after the fault is assembled. That is within one interval. Byte order and counter placement errors corrupt the decoded record at once. Faults in the session counter or the end-of-session logic appear as a wrong number of records or as `busy` falling at the wrong edge. A missing or uncleared overrun flag is checked at the end of each session.

// File: rtl/tick_sampler_pkg.sv
package tick_sampler_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } sess_state_e;

  localparam logic [7:0] CODE_SLOW = 8'd0;
  localparam logic [7:0] CODE_MID  = 8'd1;
  localparam logic [7:0] CODE_FAST = 8'd2;

  // true when the byte names one of the supported intervals
  function automatic logic code_ok(input logic [7:0] code);
    return (code == CODE_SLOW) || (code == CODE_MID) || (code == CODE_FAST);
  endfunction

  // period in cycles for an interval code
  function automatic logic [31:0] pick_period(input logic [7:0] code,
                                              input logic [31:0] p_slow,
                                              input logic [31:0] p_mid,
                                              input logic [31:0] p_fast);
    logic [31:0] p;
    case (code)
      CODE_SLOW: p = p_slow;
      CODE_MID:  p = p_mid;
      default:   p = p_fast;
    endcase
    return p;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // number of bits needed to hold values 0..v
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tick_sampler_timer.sv
module tick_sampler_timer #(
  parameter int unsigned TW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          enable,
  input  logic [TW-1:0] period_in,
  output logic          tick
);

  logic [TW-1:0] period_q;
  logic [TW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == (period_q - TW'(1)));
  assign tick   = enable && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (restart) begin
      period_q <= period_in;
      cnt_q    <= '0;
    end else if (enable) begin
      cnt_q <= at_end ? '0 : (cnt_q + TW'(1));
    end
  end

endmodule

// File: rtl/tick_sampler_sender.sv
module tick_sampler_sender #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*CNT_W-1:0] rec_in,
  input  logic               wr_done,
  output logic               wr_req,
  output logic [7:0]         wr_data,
  output logic               busy
);

  localparam int unsigned REC_W = 2 * CNT_W;
  localparam int unsigned NBYTE = REC_W / 8;
  localparam int unsigned IW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  logic [REC_W-1:0] rec_q;
  logic [IW-1:0]    idx_q;
  logic             req_q;
  logic             take;
  logic             last_byte;

  assign take      = req_q && wr_done;
  assign last_byte = (idx_q == IW'(NBYTE - 1));
  assign wr_req    = req_q;
  assign wr_data   = rec_q[REC_W-1 -: 8];
  assign busy      = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= '0;
      idx_q <= '0;
      req_q <= 1'b0;
    end else if (load) begin
      rec_q <= rec_in;
      idx_q <= '0;
      req_q <= 1'b1;
    end else if (take) begin
      if (last_byte) begin
        req_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IW'(1);
        rec_q <= {rec_q[REC_W-9:0], 8'h00};
      end
    end
  end

endmodule

// File: rtl/tick_sampler_ctrl.sv
module tick_sampler_ctrl
  import tick_sampler_pkg::*;
#(
  parameter int unsigned NSAMP = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tick,
  input  logic       snd_busy,
  output logic       accept,
  output logic       capture,
  output logic       run,
  output logic       busy,
  output logic       overrun
);

  localparam int unsigned SW = bits_for(NSAMP);

  sess_state_e   state_q;
  logic [SW-1:0] scnt_q;
  logic          ovr_q;
  logic          drop;
  logic          last_cap;

  assign accept   = (state_q == ST_IDLE) && rx_valid && code_ok(rx_data);
  assign capture  = tick && !snd_busy;
  assign drop     = tick && snd_busy;
  assign last_cap = capture && (scnt_q == SW'(NSAMP - 1));
  assign run      = (state_q == ST_RUN);
  assign busy     = (state_q != ST_IDLE);
  assign overrun  = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            scnt_q  <= '0;
            ovr_q   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (drop) ovr_q <= 1'b1;
          if (capture) scnt_q <= scnt_q + SW'(1);
          if (last_cap) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!snd_busy) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tick_sampler.sv
module tick_sampler
  import tick_sampler_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 120000,
  parameter int unsigned MID_CYC  = 60000,
  parameter int unsigned FAST_CYC = 36000,
  parameter int unsigned NSAMP    = 600,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             wr_req,
  output logic [7:0]       wr_data,
  input  logic             wr_done,
  output logic             busy,
  output logic             overrun
);

  localparam int unsigned MAXP  = max3(SLOW_CYC, MID_CYC, FAST_CYC);
  localparam int unsigned TW    = bits_for(MAXP);
  localparam int unsigned REC_W = 2 * CNT_W;

  // named internal events, observed by the bound checker
  logic             accept;
  logic             tick;
  logic             capture;
  logic             run;
  logic             snd_busy;
  logic [31:0]      period_full;
  logic [TW-1:0]    period_sel;
  logic [REC_W-1:0] snapshot;

  assign period_full = pick_period(rx_data, SLOW_CYC, MID_CYC, FAST_CYC);
  assign period_sel  = period_full[TW-1:0];
  assign snapshot    = {cnt_a, cnt_b};

  tick_sampler_ctrl #(.NSAMP(NSAMP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tick     (tick),
    .snd_busy (snd_busy),
    .accept   (accept),
    .capture  (capture),
    .run      (run),
    .busy     (busy),
    .overrun  (overrun)
  );

  tick_sampler_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .enable    (run),
    .period_in (period_sel),
    .tick      (tick)
  );

  tick_sampler_sender #(.CNT_W(CNT_W)) u_send (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (capture),
    .rec_in  (snapshot),
    .wr_done (wr_done),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .busy    (snd_busy)
  );

endmodule

// File: rtl/tick_sampler_chk.sv
module tick_sampler_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             overrun,
  input logic             wr_req,
  input logic             wr_done,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] cnt_a,
  input logic             accept,
  input logic             tick,
  input logic             capture,
  input logic             snd_busy
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_data))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_req); // R9

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy); // R4

  AST_TICK_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy); // R5

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (wr_req && wr_data == $past(cnt_a[CNT_W-1 -: 8]))); // R6

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(tick && snd_busy)); // R8

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !overrun); // R8

endmodule

bind tick_sampler tick_sampler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .overrun  (overrun),
  .wr_req   (wr_req),
  .wr_done  (wr_done),
  .wr_data  (wr_data),
  .cnt_a    (cnt_a),
  .accept   (accept),
  .tick     (tick),
  .capture  (capture),
  .snd_busy (snd_busy)
);

// File: tb/tick_sampler_test.sv
`timescale 1ns/1ps
module tick_sampler_test;

  localparam int P_SLOW = 40;
  localparam int P_MID  = 24;
  localparam int P_FAST = 16;
  localparam int NS     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic [15:0] cnt_a = 16'h0;
  logic [15:0] cnt_b = 16'h0;
  logic        wr_req;
  logic [7:0]  wr_data;
  logic        wr_done = 1'b0;
  logic        busy;
  logic        overrun;

  tick_sampler #(.SLOW_CYC(P_SLOW), .MID_CYC(P_MID), .FAST_CYC(P_FAST),
                 .NSAMP(NS), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .wr_req(wr_req), .wr_data(wr_data),
    .wr_done(wr_done), .busy(busy), .overrun(overrun));

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int ncyc = 0;
  bit stall_mode = 0;
  int wait_cnt = 0;
  int bcnt = 0;
  logic [31:0] asm_q = 32'h0;
  logic [31:0] recs [0:15];
  int nrec = 0;
  int last_done_cyc = -100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int period_of(input int code);
    if (code == 0) return P_SLOW;
    if (code == 1) return P_MID;
    return P_FAST;
  endfunction

  function automatic logic [15:0] b_of(input int n);
    return 16'((n * 3) & 16'hFFFF);
  endfunction

  // one cycle: counters encode the cycle number, sink answers the write path
  task automatic step(input bit send, input logic [7:0] cmd);
    @(negedge clk);
    ncyc++;
    cnt_a = 16'(ncyc);
    cnt_b = b_of(ncyc);
    rx_valid = send;
    rx_data = cmd;
    wr_done = 1'b0;
    if (wr_req) begin
      wait_cnt++;
      if (stall_mode ? (wait_cnt >= 30) : (($urandom % 4 != 0) || wait_cnt >= 3)) begin
        wr_done = 1'b1;
        wait_cnt = 0;
        asm_q = {asm_q[23:0], wr_data};
        bcnt++;
        if (bcnt == 4) begin
          recs[nrec] = asm_q;
          nrec++;
          bcnt = 0;
          last_done_cyc = ncyc;
        end
      end
    end else begin
      wait_cnt = 0;
    end
  endtask

  task automatic session(input int code, input bit stall, input int inj_at,
                         input logic [7:0] inj_cmd, input bit clr_check);
    int n0;
    int p;
    int prev;
    bit ended;
    p = period_of(code);
    stall_mode = stall;
    nrec = 0;
    bcnt = 0;
    step(1'b1, 8'(code));
    n0 = ncyc;
    step(1'b0, 8'h00);
    chk(busy === 1'b1, "R2", "busy after command", busy, 1);
    if (clr_check) chk(overrun === 1'b0, "R8", "overrun cleared by command", overrun, 0);
    ended = 0;
    for (int i = 0; i < 3000 && !ended; i++) begin
      step((i == inj_at), inj_cmd);
      if (nrec == NS && ncyc == last_done_cyc + 1)
        chk(busy === 1'b1 && wr_req === 1'b0, "R9", "busy held, no request after last byte",
            {busy, wr_req}, 2);
      if (nrec == NS && ncyc == last_done_cyc + 2) begin
        chk(busy === 1'b0, "R9", "busy falls at second edge", busy, 0);
        ended = 1;
      end
    end
    chk(ended && nrec == NS, "R9", "records per session", nrec, NS);
    prev = n0;
    for (int k = 1; k <= nrec; k++) begin
      int n;
      n = int'(recs[k-1][31:16]);
      chk(recs[k-1][15:0] == b_of(n), "R6", "channel 2 from same tick", recs[k-1][15:0], b_of(n));
      if (!stall) begin
        chk(n == ((n0 + k * p) & 16'hFFFF), (inj_at >= 0) ? "R4" : "R5",
            "tick cycle of record", n, (n0 + k * p) & 16'hFFFF);
      end else begin
        chk(n > prev && ((n - n0) % p) == 0, "R8", "stalled record on tick grid", n - n0, p);
      end
      prev = n;
    end
    chk(overrun === stall, "R8", "overrun at session end", overrun, stall);
    chk(busy === 1'b0 && wr_req === 1'b0, "R7", "write path quiet when idle", {busy, wr_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
    chk(wr_req === 1'b0, "R1", "wr_req after reset", wr_req, 0);
    chk(overrun === 1'b0, "R1", "overrun after reset", overrun, 0);
    rst_n = 1'b1;
    step(1'b0, 8'h00);

    // R3: unsupported codes do nothing
    step(1'b1, 8'd7);
    step(1'b1, 8'hFF);
    step(1'b1, 8'd3);
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    chk(busy === 1'b0, "R3", "busy after bad codes", busy, 0);
    chk(wr_req === 1'b0, "R3", "no request after bad codes", wr_req, 0);

    session(0, 1'b0, -1, 8'h00, 1'b0);          // R2 slow period
    session(1, 1'b0, 30, 8'h00, 1'b0);          // R4 command during session
    session(2, 1'b1, -1, 8'h00, 1'b0);          // R8 stalled sink
    session(2, 1'b0, 10, 8'h01, 1'b1);          // R10 restart, R8 clear
    for (int r = 0; r < 4; r++) begin
      int c;
      c = int'($urandom % 3);
      session(c, 1'b0, -1, 8'h00, 1'b0);        // R10 back-to-back sessions
      repeat (int'($urandom % 5)) step(1'b0, 8'h00);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule